// File: doc/BRIEF.md
# Synchronous Serial Shift Engine (Master/Slave)

This block is a full-duplex synchronous serial shifter. It works either as the clock master, making the serial clock itself, or as a clock slave that follows a clock from outside. A transfer starts when software writes a word into the transmit buffer. That word is copied into the shift register. Then, for each bit, one clock edge puts a bit on the outgoing line and the other edge takes a bit from the incoming line. At the end the received word is placed in a receive buffer and a flag is raised. The data width (2 to 16 bits), the bit order, the clock idle level and the clock phase can all be set.

In master mode the clock comes from a divider. The divider gives a single-cycle tick every `div_i + 1` system clocks. The serial clock changes level once per tick, so one bit lasts two ticks. The outgoing line keeps the last bit sent while no transfer runs. In slave mode the external clock and data are first passed through a short synchronizer. The first outgoing bit appears as soon as the buffer is written. The slave output can be driven push-pull, or it can be open-drain and shared with other slaves on a wired-AND line.

Top module: `ssc_engine`

## Requirements
- R1: A write to the transmit buffer while idle starts a transfer and sets `busy_o`. A write while `busy_o` is high is ignored, and both the word sent and the word received stay unchanged.
- R2: In master mode the first bit appears on `mosi_o` exactly `div_i + 1` cycles after the write (`div_i` >= 1). It appears only once `en_i` is high. While `en_i` is low a loaded master holds `mosi_o` and produces no clock.
- R3: In slave mode the first bit appears on `sdo_o` in the cycle right after the write, before any serial clock edge.
- R4: Each bit is driven on one serial clock edge and sampled on the other. With `cpha_i`=0 sampling happens on the edge that leaves the idle level. With `cpha_i`=1 sampling happens on the edge that returns to the idle level.
- R5: An enabled master with no transfer running holds `sclk_o` at `cpol_i`. It is also back at that level when a transfer ends.
- R6: After a master transfer, `mosi_o` keeps the level of the last bit sent until the next transfer begins.
- R7: After `width_i` clock pulses (2..16), the received word appears right-aligned on `rx_data_o`, with the upper bits zero, and `rx_full_o` is set. This holds in both modes.
- R8: `msb_i`=1 sends and receives the most significant bit first. `msb_i`=0 sends and receives the least significant bit first.
- R9: In open-drain slave mode (`od_i`=1), `sdo_o` is 0. The driver (`sdo_oe_o`) is on only for a 0 bit, so a 1 bit leaves the line to the pull-up.
- R10: A slave whose `sel_i` is low keeps `sdo_oe_o` low. It ignores serial clock edges, so its shift state does not advance.
- R11: A pulse on `rx_rd_i` clears `rx_full_o`. If a transfer completes in the same cycle, setting the flag wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Serial engine enable |
| master_i | input | 1 | 1 = clock master, 0 = clock slave |
| msb_i | input | 1 | 1 = MSB first, 0 = LSB first |
| cpol_i | input | 1 | Idle level of the serial clock |
| cpha_i | input | 1 | 0 = sample on leaving idle, 1 = sample on returning to idle |
| od_i | input | 1 | Slave output style: 1 = open-drain, 0 = push-pull |
| width_i | input | 5 | Bits per transfer, 2..16 |
| div_i | input | 8 | Baud divider; one tick every div_i+1 cycles |
| tx_wr_i | input | 1 | Transmit buffer write strobe |
| tx_data_i | input | 16 | Transmit word, right-aligned |
| rx_rd_i | input | 1 | Receive buffer read strobe |
| rx_data_o | output | 16 | Receive buffer |
| rx_full_o | output | 1 | Receive-complete flag |
| busy_o | output | 1 | Transfer loaded or running |
| sclk_o | output | 1 | Master serial clock |
| mosi_o | output | 1 | Master data out |
| miso_i | input | 1 | Master data in |
| sclk_i | input | 1 | Slave serial clock in |
| sdi_i | input | 1 | Slave data in |
| sel_i | input | 1 | Slave select |
| sdo_o | output | 1 | Slave data out |
| sdo_oe_o | output | 1 | Slave output driver enable |

## Verification
The hardest case to reach from the ports is a slave that has been loaded but is deselected while the serial clock keeps toggling. Nothing can be seen in that state: the output is off and no flag moves. To show that no shifting took place, the bench loads a slave with `sel_i` low and toggles `sclk_i` several times. It then selects the slave and runs a full transfer. The exact word the bench captures on the line proves the shift state never advanced. The master's wait for its first bit is reached by writing with `en_i` low and then counting cycles from the moment the enable is raised.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_RUN  = 2'd2
    } ph_e;
endpackage

// File: rtl/ssc_baud.sv
module ssc_baud #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_i,
    input  logic [DIVW-1:0] div_i,
    output logic            tick_o
);
    logic [DIVW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && (cnt_q == div_i);
        if (!run_i || tick_o) cnt_d = '0;
        else                  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/ssc_sync.sv
module ssc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic sdi_i,
    output logic lvl_o,
    output logic dat_o,
    output logic edge_o
);
    logic [STAGES-1:0] ck_d, ck_q, dt_d, dt_q;
    logic              prev_d, prev_q;

    always_comb begin
        ck_d   = {ck_q[STAGES-2:0], sclk_i};
        dt_d   = {dt_q[STAGES-2:0], sdi_i};
        prev_d = ck_q[STAGES-1];
        lvl_o  = ck_q[STAGES-1];
        dat_o  = dt_q[STAGES-1];
        edge_o = ck_q[STAGES-1] != prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ck_q   <= '0;
            dt_q   <= '0;
            prev_q <= 1'b0;
        end else begin
            ck_q   <= ck_d;
            dt_q   <= dt_d;
            prev_q <= prev_d;
        end
    end
endmodule

// File: rtl/ssc_engine.sv
module ssc_engine
    import ssc_pkg::*;
#(
    parameter int MAXW   = 16,
    parameter int DIVW   = 8,
    parameter int SYNC_N = 2,
    localparam int NW    = $clog2(MAXW + 1),
    localparam int CW    = $clog2(2 * MAXW + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic            master_i,
    input  logic            msb_i,
    input  logic            cpol_i,
    input  logic            cpha_i,
    input  logic            od_i,
    input  logic [NW-1:0]   width_i,
    input  logic [DIVW-1:0] div_i,
    input  logic            tx_wr_i,
    input  logic [MAXW-1:0] tx_data_i,
    input  logic            rx_rd_i,
    output logic [MAXW-1:0] rx_data_o,
    output logic            rx_full_o,
    output logic            busy_o,
    output logic            sclk_o,
    output logic            mosi_o,
    input  logic            miso_i,
    input  logic            sclk_i,
    input  logic            sdi_i,
    input  logic            sel_i,
    output logic            sdo_o,
    output logic            sdo_oe_o
);
    typedef struct packed {
        ph_e             ph;
        logic [CW-1:0]   ec;
        logic [NW-1:0]   nb;
        logic [MAXW-1:0] txs;
        logic [MAXW-1:0] rxs;
        logic [MAXW-1:0] rxb;
        logic            full;
        logic            dout;
        logic            sclk;
    } st_t;

    st_t s_d, s_q;
    logic tick, s_lvl, s_dat, s_edge;

    ssc_baud #(.DIVW(DIVW)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (en_i && master_i && (s_q.ph != PH_IDLE)),
        .div_i (div_i),
        .tick_o(tick)
    );

    ssc_sync #(.STAGES(SYNC_N)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .sclk_i(sclk_i),
        .sdi_i (sdi_i),
        .lvl_o (s_lvl),
        .dat_o (s_dat),
        .edge_o(s_edge)
    );

    function automatic logic head(input logic [MAXW-1:0] v, input logic msb,
                                  input logic [NW-1:0] w);
        return msb ? v[w - 1'b1] : v[0];
    endfunction

    logic [MAXW-1:0] mask, shifted;
    logic            evt, lead, samp, din, shift_ok;

    always_comb begin
        s_d      = s_q;
        mask     = {MAXW{1'b1}} >> (MAXW - int'(width_i));
        shifted  = msb_i ? (s_q.txs << 1) : (s_q.txs >> 1);
        din      = master_i ? miso_i : s_dat;
        evt      = (s_q.ph == PH_RUN) &&
                   (master_i ? tick : (sel_i && en_i && s_edge));
        lead     = master_i ? (s_q.sclk == cpol_i) : (s_lvl != cpol_i);
        samp     = lead ^ cpha_i;
        shift_ok = cpha_i ? (s_q.nb != '0) : (s_q.nb != width_i);

        if (rx_rd_i) s_d.full = 1'b0;
        if (s_q.ph != PH_RUN) s_d.sclk = cpol_i;

        if (s_q.ph == PH_IDLE && tx_wr_i) begin
            s_d.txs = tx_data_i;
            s_d.rxs = '0;
            s_d.ec  = '0;
            s_d.nb  = '0;
            if (master_i) begin
                s_d.ph = PH_WAIT;
            end else begin
                s_d.ph   = PH_RUN;
                s_d.dout = head(tx_data_i, msb_i, width_i);
            end
        end else if (s_q.ph == PH_WAIT && tick) begin
            s_d.ph   = PH_RUN;
            s_d.dout = head(s_q.txs, msb_i, width_i);
        end else if (evt) begin
            if (master_i) s_d.sclk = ~s_q.sclk;
            if (samp) begin
                s_d.nb  = s_q.nb + 1'b1;
                s_d.rxs = msb_i ? {s_q.rxs[MAXW-2:0], din}
                                : ((s_q.rxs >> 1) | (MAXW'(din) << (width_i - 1'b1)));
            end else if (shift_ok) begin
                s_d.txs  = shifted;
                s_d.dout = head(shifted, msb_i, width_i);
            end
            s_d.ec = s_q.ec + 1'b1;
            if (CW'(s_q.ec + 1'b1) == CW'({width_i, 1'b0})) begin
                s_d.rxb  = s_d.rxs & mask;
                s_d.full = 1'b1;
                s_d.ph   = PH_IDLE;
            end
        end

        rx_data_o = s_q.rxb;
        rx_full_o = s_q.full;
        busy_o    = s_q.ph != PH_IDLE;
        sclk_o    = (en_i && master_i) ? s_q.sclk : 1'b0;
        mosi_o    = s_q.dout;
        if (master_i || !sel_i || !en_i) begin
            sdo_o    = s_q.dout;
            sdo_oe_o = 1'b0;
        end else if (od_i) begin
            sdo_o    = 1'b0;
            sdo_oe_o = ~s_q.dout;
        end else begin
            sdo_o    = s_q.dout;
            sdo_oe_o = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.ph   <= PH_IDLE;
            s_q.dout <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/ssc_engine_chk.sv
module ssc_engine_chk #(
    parameter int MAXW = 16,
    parameter int NW   = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            en_i,
    input logic            master_i,
    input logic            msb_i,
    input logic            cpol_i,
    input logic            od_i,
    input logic [NW-1:0]   width_i,
    input logic            tx_wr_i,
    input logic [MAXW-1:0] tx_data_i,
    input logic            rx_rd_i,
    input logic            rx_full_o,
    input logic            busy_o,
    input logic            sclk_o,
    input logic            mosi_o,
    input logic            sel_i,
    input logic            sdo_o,
    input logic            sdo_oe_o
);
    AST_MASTER_WAITS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        master_i && $rose(busy_o) |=> $stable(mosi_o)); // R2

    AST_SLAVE_FIRST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        !master_i && en_i && sel_i && !od_i && $rose(busy_o) && $past(tx_wr_i) |->
        sdo_o == (msb_i ? $past(tx_data_i[width_i - 1'b1]) : $past(tx_data_i[0]))); // R3

    AST_IDLE_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
        en_i && master_i && !busy_o && $past(!busy_o) && $stable(cpol_i) |-> sclk_o == cpol_i); // R5

    AST_LAST_BIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        master_i && !busy_o && $past(!busy_o) |-> $stable(mosi_o)); // R6

    AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> rx_full_o); // R7

    AST_WIDTH_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (width_i >= 2) && (int'(width_i) <= MAXW)); // R7

    AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        od_i && !master_i && sdo_oe_o |-> !sdo_o); // R9

    AST_UNSEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !master_i && !sel_i |-> !sdo_oe_o); // R10

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rd_i |=> (!rx_full_o || $fell(busy_o))); // R11
endmodule

bind ssc_engine ssc_engine_chk #(.MAXW(MAXW), .NW(NW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en_i),
    .master_i (master_i),
    .msb_i    (msb_i),
    .cpol_i   (cpol_i),
    .od_i     (od_i),
    .width_i  (width_i),
    .tx_wr_i  (tx_wr_i),
    .tx_data_i(tx_data_i),
    .rx_rd_i  (rx_rd_i),
    .rx_full_o(rx_full_o),
    .busy_o   (busy_o),
    .sclk_o   (sclk_o),
    .mosi_o   (mosi_o),
    .sel_i    (sel_i),
    .sdo_o    (sdo_o),
    .sdo_oe_o (sdo_oe_o)
);

// File: tb/sim_ssc_engine.sv
module sim_ssc_engine;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n, en, master, msb, cpol, cpha, od, tx_wr, rx_rd, sclk_in, sdi, sel;
    logic [4:0]  wid;
    logic [7:0]  div;
    logic [15:0] tx_data, rx_data;
    logic        rx_full, busy, sclk_o, mosi, miso, sdo, sdo_oe;

    assign miso = ~mosi;

    ssc_engine u0 (
        .clk(clk), .rst_n(rst_n), .en_i(en), .master_i(master), .msb_i(msb),
        .cpol_i(cpol), .cpha_i(cpha), .od_i(od), .width_i(wid), .div_i(div),
        .tx_wr_i(tx_wr), .tx_data_i(tx_data), .rx_rd_i(rx_rd), .rx_data_o(rx_data),
        .rx_full_o(rx_full), .busy_o(busy), .sclk_o(sclk_o), .mosi_o(mosi),
        .miso_i(miso), .sclk_i(sclk_in), .sdi_i(sdi), .sel_i(sel),
        .sdo_o(sdo), .sdo_oe_o(sdo_oe)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // {msb, cpol, cpha, width, tx word, expected rx word (inverted loopback)}
    localparam logic [39:0] VEC [6] = '{
        {1'b1, 1'b0, 1'b0, 5'd8,  16'h00A5, 16'h005A},
        {1'b0, 1'b0, 1'b1, 5'd8,  16'h0031, 16'h00CE},
        {1'b1, 1'b1, 1'b0, 5'd16, 16'hBEEF, 16'h4110},
        {1'b0, 1'b1, 1'b1, 5'd16, 16'h1234, 16'hEDCB},
        {1'b1, 1'b0, 1'b1, 5'd2,  16'h0002, 16'h0001},
        {1'b0, 1'b1, 1'b0, 5'd5,  16'h0013, 16'h000C}
    };

    // monitor of the master's line at its sampling edges
    logic        mon_clr = 1'b1;
    logic [15:0] cap = '0;
    int          capn = 0;
    logic        prev_sclk = 1'b0;
    always @(negedge clk) begin
        prev_sclk <= sclk_o;
        if (mon_clr) begin
            cap  <= '0;
            capn <= 0;
        end else if (sclk_o !== prev_sclk && ((sclk_o !== cpol) ^ cpha)) begin
            if (msb) cap <= {cap[14:0], mosi};
            else     cap[capn[3:0]] <= mosi;
            capn <= capn + 1;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic write_tx(input logic [15:0] v);
        @(posedge clk); #1 tx_wr = 1'b1; tx_data = v;
        @(posedge clk); #1 tx_wr = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (rx_full !== 1'b1 && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(req, {31'd0, rx_full}, 32'd1);
        @(negedge clk);
    endtask

    task automatic read_rx();
        @(posedge clk); #1 rx_rd = 1'b1;
        @(posedge clk); #1 rx_rd = 1'b0;
        @(negedge clk);
        chk("R11 flag cleared by read", {31'd0, rx_full}, 32'd0);
    endtask

    task automatic mon_reset();
        step(4);
        mon_clr = 1'b1;
        step(2);
        mon_clr = 1'b0;
    endtask

    logic [15:0] scap;
    logic        od_bad;

    task automatic drive_slave(input logic [15:0] mw);
        scap   = '0;
        od_bad = 1'b0;
        for (int k = 0; k < int'(wid); k++) begin
            int idx;
            idx = msb ? int'(wid) - 1 - k : k;
            if (!cpha) begin
                sdi = mw[idx];
                step(8);
                scap[idx] = sdo_oe ? sdo : 1'b1;
                if (od && sdo_oe && sdo) od_bad = 1'b1;
                sclk_in = ~cpol;
                step(8);
                sclk_in = cpol;
            end else begin
                sclk_in = ~cpol;
                step(4);
                sdi = mw[idx];
                step(4);
                scap[idx] = sdo_oe ? sdo : 1'b1;
                if (od && sdo_oe && sdo) od_bad = 1'b1;
                sclk_in = cpol;
                step(8);
            end
        end
        step(8);
    endtask

    initial begin
        #4000000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; en = 1'b0; master = 1'b1; msb = 1'b1; cpol = 1'b0; cpha = 1'b0;
        od = 1'b0; tx_wr = 1'b0; rx_rd = 1'b0; sclk_in = 1'b0; sdi = 1'b0; sel = 1'b0;
        wid = 5'd8; div = 8'd10; tx_data = '0;
        step(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk("reset rx_full", {31'd0, rx_full}, 32'd0);
        chk("reset busy", {31'd0, busy}, 32'd0);
        chk("reset sclk_o", {31'd0, sclk_o}, 32'd0);
        chk("reset mosi idle", {31'd0, mosi}, 32'd1);

        // R2: loaded while disabled, then first bit exactly div+1 cycles after enable
        write_tx(16'h0000);
        step(40);
        chk("R1 busy after write", {31'd0, busy}, 32'd1);
        chk("R2 disabled holds mosi", {31'd0, mosi}, 32'd1);
        chk("R2 disabled no clock", {31'd0, sclk_o}, 32'd0);
        en = 1'b1;
        step(10);
        @(negedge clk);
        chk("R2 first bit not before tick", {31'd0, mosi}, 32'd1);
        @(negedge clk);
        chk("R2 first bit at tick", {31'd0, mosi}, 32'd0);
        wait_done("R7 master done");
        read_rx();

        // main table: master with inverted loopback
        div = 8'd2;
        for (int i = 0; i < 6; i++) begin
            logic [39:0] v;
            logic        lastb;
            v = VEC[i];
            msb = v[39]; cpol = v[38]; cpha = v[37]; wid = v[36:32];
            mon_reset();
            write_tx(v[31:16]);
            wait_done("R7 flag set");
            chk("R7 R8 received word", {16'd0, rx_data}, {16'd0, v[15:0]});
            chk("R4 R8 word on line", {16'd0, cap}, {16'd0, v[31:16]});
            lastb = msb ? v[16] : v[16 + int'(wid) - 1];
            chk("R6 last bit held", {31'd0, mosi}, {31'd0, lastb});
            step(6);
            chk("R6 still held", {31'd0, mosi}, {31'd0, lastb});
            chk("R5 idle clock level", {31'd0, sclk_o}, {31'd0, cpol});
            read_rx();
        end

        // R1: write during a transfer is ignored
        msb = 1'b1; cpol = 1'b0; cpha = 1'b0; wid = 5'd8;
        mon_reset();
        write_tx(16'h005A);
        step(20);
        write_tx(16'h00FF);
        wait_done("R1 done");
        chk("R1 line unaffected", {16'd0, cap}, 32'h005A);
        chk("R1 rx unaffected", {16'd0, rx_data}, 32'h00A5);
        read_rx();

        // slave push-pull, selected
        master = 1'b0; sel = 1'b1; od = 1'b0; msb = 1'b1; cpol = 1'b0; cpha = 1'b0;
        wid = 5'd8; sclk_in = 1'b0;
        step(8);
        write_tx(16'h0069);
        @(negedge clk);
        chk("R3 first bit driven at once", {30'd0, sdo_oe, sdo}, 32'h2);
        drive_slave(16'h003C);
        chk("R4 R8 slave line word", {16'd0, scap}, 32'h0069);
        chk("R7 slave rx word", {16'd0, rx_data}, 32'h003C);
        chk("R7 slave flag", {31'd0, rx_full}, 32'd1);
        read_rx();

        // R10: deselected slave ignores clock edges
        sel = 1'b0;
        write_tx(16'h0096);
        for (int j = 0; j < 4; j++) begin
            sclk_in = ~sclk_in;
            step(8);
        end
        @(negedge clk);
        chk("R10 unselected driver off", {31'd0, sdo_oe}, 32'd0);
        chk("R10 still loaded", {31'd0, busy}, 32'd1);
        sel = 1'b1;
        step(8);
        drive_slave(16'h00C3);
        chk("R10 no shift while unselected", {16'd0, scap}, 32'h0096);
        chk("R10 rx after select", {16'd0, rx_data}, 32'h00C3);
        read_rx();

        // R9: open-drain slave, LSB first, cpol 1, cpha 1, 12 bits
        od = 1'b1; msb = 1'b0; cpol = 1'b1; cpha = 1'b1; wid = 5'd12; sclk_in = 1'b1;
        step(8);
        write_tx(16'h05A3);
        drive_slave(16'h0A5C);
        chk("R9 wired line word", {16'd0, scap}, 32'h05A3);
        chk("R9 never drives high", {31'd0, od_bad}, 32'd0);
        chk("R7 R8 od rx word", {16'd0, rx_data}, 32'h0A5C);
        sel = 1'b0;
        @(negedge clk);
        chk("R10 od unselected off", {31'd0, sdo_oe}, 32'd0);
        read_rx();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule